// File: doc/BRIEF.md
# Floating-point conditional compare unit

This block executes one predicated floating-point compare per request. It decodes a 32-bit instruction word and reads from it the precision, a condition code and a 4-bit fallback flag value. It tests the condition against the incoming NZCV flags. When the condition holds, it compares two operands taken from the low bits of two 64-bit register values, at half, single or double precision, and turns the ordering into new NZCV flags. When the condition fails, the fallback value becomes the new flags.

A signaling NaN operand in an executed compare raises an invalid-operation indication. A quiet NaN only yields the unordered flag pattern. A word that does not match the format, or that selects a precision which is unavailable, is reported as undefined and the flags pass through unchanged. Each accepted request produces a registered result one cycle later, marked by a one-cycle valid pulse.

Top module: `fp_ccmp_unit`

## Requirements
- R1: A word is recognised only when bits 31..24 are 00011110, bit 21 is 1, bits 11..10 are 01 and bit 4 is 0. A word that is not recognised, a type field (bits 23..22) of 10, or a type field of 11 while `half_en` is low, sets `undef_op`, copies `flags_in` to `flags_out` and keeps `invalid_op` low.
- R2: When the condition (bits 15..12) does not hold on `flags_in`, `flags_out` equals the immediate in bits 3..0 and `invalid_op` is low, even when the operands are NaNs.
- R3: Conditions use the standard 16-code table with flag order N,Z,C,V in bits 3..0. Codes 0000/0001 test Z set/clear, 0010/0011 C, 0100/0101 N, 0110/0111 V. 1000 is C and not Z, 1010 is N==V, 1100 is not Z and N==V. Each odd code below 1111 is the inverse of the code below it. 1110 and 1111 always pass.
- R4: An ordered compare gives NZCV 1000 for less-than, 0110 for equal and 0010 for greater-than.
- R5: If either operand is a NaN, NZCV is 0011.
- R6: `invalid_op` is high only when an executed compare has an operand with an all-ones exponent, a nonzero fraction and a clear top fraction bit.
- R7: +0 equals -0. Infinities order by sign. Subnormal and normal values order by sign and then by the magnitude of their exponent and fraction bits.
- R8: Type 00 compares bits 31..0 as single precision and type 01 compares bits 63..0 as double precision. Bits above the selected width have no effect.
- R9: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high. With `in_valid` low, the result outputs hold their values.
- R10: Type 11 with `half_en` high compares bits 15..0 as half precision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| opa | input | 64 | First operand register value |
| opb | input | 64 | Second operand register value |
| flags_in | input | 4 | Current NZCV flags |
| half_en | input | 1 | Half-precision support present |
| out_valid | output | 1 | Result strobe, one cycle per request |
| flags_out | output | 4 | New NZCV flags |
| invalid_op | output | 1 | Invalid-operation exception flag |
| undef_op | output | 1 | Undefined instruction indication |

## Verification
The bench targets the signed-zero pair and negative operands whose magnitudes run the opposite way to their values. A plain integer compare would call those unequal or reversed. It sends a failed condition with signaling-NaN operands, which a design that compares unconditionally would flag as invalid. It fills the upper register bits with patterns that form NaNs at a wider precision, which exposes a wrong operand slice. It also walks every condition-code family, including the odd-code inversions and the never-fails code 1111, sends a half-precision word with support off, and checks that the outputs hold and the valid pulse stays at one cycle across back-to-back and idle cycles.

// File: rtl/fccmp_pkg.sv
package fccmp_pkg;
  localparam int INSTR_W = 32;
  localparam int REG_W   = 64;
  localparam int FLAG_W  = 4;
  localparam int NUM_FMT = 3;

  typedef enum logic [1:0] {
    FT_SINGLE = 2'b00,
    FT_DOUBLE = 2'b01,
    FT_RSVD   = 2'b10,
    FT_HALF   = 2'b11
  } ftype_e;

  typedef struct packed {
    ftype_e              ftype;
    logic [4:0]          src_m;
    logic [3:0]          cond;
    logic [4:0]          src_n;
    logic [FLAG_W-1:0]   imm;
  } ccmp_fields_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic gt;
    logic unord;
    logic snan;
  } cmp_res_t;

  // format index 0 = half, 1 = single, 2 = double
  function automatic int fmt_exp_w(int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int fmt_frac_w(int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

  function automatic logic [1:0] ftype_to_idx(ftype_e ft);
    case (ft)
      FT_HALF:   return 2'd0;
      FT_SINGLE: return 2'd1;
      default:   return 2'd2;
    endcase
  endfunction

  // flag order: [3]=N [2]=Z [1]=C [0]=V
  function automatic logic cond_holds(logic [3:0] cond, logic [FLAG_W-1:0] f);
    logic base;
    case (cond[3:1])
      3'b000: base = f[2];
      3'b001: base = f[1];
      3'b010: base = f[3];
      3'b011: base = f[0];
      3'b100: base = f[1] & ~f[2];
      3'b101: base = (f[3] == f[0]);
      3'b110: base = ~f[2] & (f[3] == f[0]);
      default: base = 1'b1;
    endcase
    if (cond[0] && cond != 4'b1111) return ~base;
    return base;
  endfunction

  function automatic logic [FLAG_W-1:0] cmp_to_nzcv(cmp_res_t r);
    if (r.unord)   return 4'b0011;
    else if (r.lt) return 4'b1000;
    else if (r.eq) return 4'b0110;
    return 4'b0010;
  endfunction
endpackage

// File: rtl/fcc_decode.sv
module fcc_decode
  import fccmp_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic               half_en,
  output ccmp_fields_t       fields,
  output logic               undef
);
  logic fmt_match;

  always_comb begin
    fmt_match = (instr[31:24] == 8'b0001_1110) && instr[21]
              && (instr[11:10] == 2'b01) && !instr[4];
    fields.ftype = ftype_e'(instr[23:22]);
    fields.src_m = instr[20:16];
    fields.cond  = instr[15:12];
    fields.src_n = instr[9:5];
    fields.imm   = instr[3:0];
    undef = !fmt_match
          || (fields.ftype == FT_RSVD)
          || (fields.ftype == FT_HALF && !half_en);
  end
endmodule

// File: rtl/fcc_cond.sv
module fcc_cond
  import fccmp_pkg::*;
(
  input  logic [3:0]        cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              pass
);
  always_comb pass = cond_holds(cond, flags);
endmodule

// File: rtl/fcc_fpcmp.sv
module fcc_fpcmp
  import fccmp_pkg::*;
#(
  parameter  int EXP_W  = 8,
  parameter  int FRAC_W = 23,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output cmp_res_t     res
);
  function automatic logic is_nan(logic [W-1:0] x);
    return (&x[W-2:FRAC_W]) && (|x[FRAC_W-1:0]);
  endfunction

  function automatic logic is_snan(logic [W-1:0] x);
    return is_nan(x) && !x[FRAC_W-1];
  endfunction

  // signed-magnitude ordering for non-NaN, non-equal operands
  function automatic logic ordered_less(logic [W-1:0] x, logic [W-1:0] y);
    if (x[W-1] != y[W-1]) return x[W-1];
    if (x[W-1])           return x[W-2:0] > y[W-2:0];
    return x[W-2:0] < y[W-2:0];
  endfunction

  logic both_zero;

  always_comb begin
    both_zero = ~|a[W-2:0] && ~|b[W-2:0];
    res.unord = is_nan(a) || is_nan(b);
    res.snan  = is_snan(a) || is_snan(b);
    res.eq    = !res.unord && (both_zero || a == b);
    res.lt    = !res.unord && !res.eq && ordered_less(a, b);
    res.gt    = !res.unord && !res.eq && !res.lt;
  end
endmodule

// File: rtl/fp_ccmp_unit.sv
module fp_ccmp_unit
  import fccmp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [63:0]        opa,
  input  logic [63:0]        opb,
  input  logic [3:0]         flags_in,
  input  logic               half_en,
  output logic               out_valid,
  output logic [3:0]         flags_out,
  output logic               invalid_op,
  output logic               undef_op
);
  ccmp_fields_t      dec_fields;
  logic              dec_undef;
  logic              cond_pass;
  cmp_res_t          fmt_res [NUM_FMT];
  cmp_res_t          cmp_sel;
  logic [1:0]        fmt_idx;
  logic              issue_cmp;
  logic [FLAG_W-1:0] nxt_flags;
  logic              nxt_inv;

  fcc_decode u_decode (
    .instr   (instr),
    .half_en (half_en),
    .fields  (dec_fields),
    .undef   (dec_undef)
  );

  fcc_cond u_cond (
    .cond  (dec_fields.cond),
    .flags (flags_in),
    .pass  (cond_pass)
  );

  for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
    localparam int EW = fmt_exp_w(gi);
    localparam int FW = fmt_frac_w(gi);
    localparam int OW = 1 + EW + FW;
    fcc_fpcmp #(.EXP_W(EW), .FRAC_W(FW)) u_cmp (
      .a   (opa[OW-1:0]),
      .b   (opb[OW-1:0]),
      .res (fmt_res[gi])
    );
  end

  always_comb begin
    fmt_idx   = ftype_to_idx(dec_fields.ftype);
    cmp_sel   = fmt_res[fmt_idx];
    issue_cmp = !dec_undef && cond_pass;
    nxt_flags = flags_in;
    nxt_inv   = 1'b0;
    if (!dec_undef) begin
      if (cond_pass) begin
        nxt_flags = cmp_to_nzcv(cmp_sel);
        nxt_inv   = cmp_sel.snan;
      end else begin
        nxt_flags = dec_fields.imm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      flags_out  <= '0;
      invalid_op <= 1'b0;
      undef_op   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        flags_out  <= nxt_flags;
        invalid_op <= nxt_inv;
        undef_op   <= dec_undef;
      end
    end
  end

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable({flags_out, invalid_op, undef_op}));
  // R1
  undef_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_undef) |=> (undef_op && !invalid_op && flags_out == $past(flags_in)));
  // R2
  cond_fail_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dec_undef && !cond_pass) |=>
      (flags_out == $past(dec_fields.imm) && !invalid_op));
  // R4
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_cmp |-> $onehot({cmp_sel.lt, cmp_sel.eq, cmp_sel.gt, cmp_sel.unord}));
  // R6
  invalid_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid_op) |-> (flags_out == 4'b0011 && !undef_op));
  // R5
  snan_is_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_cmp && cmp_sel.snan) |-> cmp_sel.unord);
endmodule

// File: tb/fp_ccmp_unit_tb.sv
`timescale 1ns/100ps
module fp_ccmp_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr;
  logic [63:0] opa, opb;
  logic [3:0]  flags_in;
  logic        half_en;
  logic        out_valid;
  logic [3:0]  flags_out;
  logic        invalid_op, undef_op;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fp_ccmp_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opa(opa), .opb(opb), .flags_in(flags_in), .half_en(half_en),
    .out_valid(out_valid), .flags_out(flags_out),
    .invalid_op(invalid_op), .undef_op(undef_op)
  );

  typedef struct packed {
    logic        bad;
    logic [1:0]  ft;
    logic [3:0]  cnd;
    logic [3:0]  imm;
    logic [63:0] a;
    logic [63:0] b;
    logic [3:0]  fin;
    logic        hen;
    logic [3:0]  ef;
    logic        ei;
    logic        eu;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'b00,4'he,4'h0,64'h3F800000,64'h40000000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd4},   // R4 1<2
    '{1'b0,2'b00,4'he,4'h0,64'h40000000,64'h3F800000,4'h0,1'b1,4'b0010,1'b0,1'b0,8'd4},   // R4 2>1
    '{1'b0,2'b00,4'he,4'h0,64'h3F800000,64'h3F800000,4'h0,1'b1,4'b0110,1'b0,1'b0,8'd4},   // R4 equal
    '{1'b0,2'b00,4'he,4'h0,64'h00000000,64'h80000000,4'h0,1'b1,4'b0110,1'b0,1'b0,8'd7},   // R7 +0 == -0
    '{1'b0,2'b00,4'he,4'h0,64'hFF800000,64'h7F800000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd7},   // R7 -inf < +inf
    '{1'b0,2'b00,4'he,4'h0,64'hBF800000,64'hC0000000,4'h0,1'b1,4'b0010,1'b0,1'b0,8'd7},   // R7 -1 > -2
    '{1'b0,2'b00,4'he,4'h0,64'h00000001,64'h00000000,4'h0,1'b1,4'b0010,1'b0,1'b0,8'd7},   // R7 subnormal > 0
    '{1'b0,2'b00,4'he,4'h0,64'h7FC00000,64'h3F800000,4'h0,1'b1,4'b0011,1'b0,1'b0,8'd5},   // R5 qNaN
    '{1'b0,2'b00,4'he,4'h0,64'h3F800000,64'h7F800001,4'h0,1'b1,4'b0011,1'b1,1'b0,8'd6},   // R6 sNaN
    '{1'b0,2'b01,4'he,4'h0,64'h3FF0000000000000,64'h4000000000000000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd8}, // R8 double
    '{1'b0,2'b01,4'he,4'h0,64'h7FF0000000000001,64'h7FF8000000000000,4'h0,1'b1,4'b0011,1'b1,1'b0,8'd6}, // R6 double sNaN
    '{1'b0,2'b00,4'he,4'h0,64'hDEADBEEF3F800000,64'h123456783F800000,4'h0,1'b1,4'b0110,1'b0,1'b0,8'd8}, // R8 upper ignored
    '{1'b0,2'b11,4'he,4'h0,64'hFFFFFFFFFFFF3C00,64'hFFFFFFFFFFFF4000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd10}, // R10 half
    '{1'b0,2'b11,4'he,4'h0,64'h000000000000C000,64'h7FFFFFFFFFFF3C00,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd10}, // R10 -2<1
    '{1'b0,2'b11,4'he,4'h0,64'h3C00,64'h4000,4'b1010,1'b0,4'b1010,1'b0,1'b1,8'd1},        // R1 half off
    '{1'b0,2'b10,4'he,4'h0,64'h3F800000,64'h40000000,4'b0101,1'b1,4'b0101,1'b0,1'b1,8'd1},// R1 type 10
    '{1'b1,2'b00,4'he,4'h0,64'h7F800001,64'h40000000,4'b1100,1'b1,4'b1100,1'b0,1'b1,8'd1},// R1 bad bit4
    '{1'b0,2'b00,4'h0,4'b1011,64'h7F800001,64'h7F800001,4'h0,1'b1,4'b1011,1'b0,1'b0,8'd2},// R2 fail, sNaN ignored
    '{1'b0,2'b00,4'h1,4'h0,64'h3F800000,64'h40000000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd3},   // R3 NE pass
    '{1'b0,2'b00,4'h8,4'h0,64'h3F800000,64'h3F800000,4'b0010,1'b1,4'b0110,1'b0,1'b0,8'd3},// R3 HI pass
    '{1'b0,2'b00,4'h8,4'b0001,64'h3F800000,64'h3F800000,4'b0110,1'b1,4'b0001,1'b0,1'b0,8'd3}, // R3 HI fail
    '{1'b0,2'b00,4'ha,4'h0,64'h40000000,64'h3F800000,4'b1001,1'b1,4'b0010,1'b0,1'b0,8'd3},// R3 GE pass
    '{1'b0,2'b00,4'hb,4'b0100,64'h40000000,64'h3F800000,4'b1001,1'b1,4'b0100,1'b0,1'b0,8'd3}, // R3 LT fail
    '{1'b0,2'b00,4'hc,4'h0,64'h3F800000,64'h40000000,4'h0,1'b1,4'b1000,1'b0,1'b0,8'd3},   // R3 GT pass
    '{1'b0,2'b00,4'hd,4'h0,64'h3F800000,64'h3F800000,4'b0100,1'b1,4'b0110,1'b0,1'b0,8'd3},// R3 LE pass
    '{1'b0,2'b00,4'hf,4'h0,64'h40000000,64'h3F800000,4'h0,1'b1,4'b0010,1'b0,1'b0,8'd3},   // R3 1111 pass
    '{1'b0,2'b00,4'h4,4'b1111,64'h3F800000,64'h3F800000,4'h0,1'b1,4'b1111,1'b0,1'b0,8'd3},// R3 MI fail
    '{1'b0,2'b00,4'h7,4'b0000,64'h3F800000,64'h3F800000,4'b0001,1'b1,4'b0000,1'b0,1'b0,8'd3}, // R3 VC fail
    '{1'b0,2'b00,4'h3,4'b1100,64'h3F800000,64'h3F800000,4'b0010,1'b1,4'b1100,1'b0,1'b0,8'd3}  // R3 CC fail
  };

  function automatic logic [31:0] encode(logic bad, logic [1:0] ft, logic [3:0] c, logic [3:0] imm);
    return {8'b0001_1110, ft, 1'b1, 5'd3, c, 2'b01, 5'd7, bad, imm};
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual valid/nzcv/inv/und=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    @(negedge clk);
    instr    = encode(v.bad, v.ft, v.cnd, v.imm);
    opa      = v.a;
    opb      = v.b;
    flags_in = v.fin;
    half_en  = v.hen;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; opa = '0; opb = '0;
    flags_in = '0; half_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset", {out_valid, flags_out, invalid_op, undef_op}, 7'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check($sformatf("R%0d vec%0d", VECS[i].req, i),
            {out_valid, flags_out, invalid_op, undef_op},
            {1'b1, VECS[i].ef, VECS[i].ei, VECS[i].eu});
    end

    // R9 hold while idle, valid low
    repeat (3) @(negedge clk);
    check("R9 idle hold", {out_valid, flags_out, invalid_op, undef_op},
          {1'b0, 4'b1100, 1'b0, 1'b0});

    // R9 back-to-back requests: two pulses, each result in its own cycle
    @(negedge clk);
    instr = encode(1'b0, 2'b00, 4'he, 4'h0);
    opa = 64'h7F800001; opb = 64'h3F800000; flags_in = 4'h0; half_en = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    check("R9 b2b first", {out_valid, flags_out, invalid_op, undef_op},
          {1'b1, 4'b0011, 1'b1, 1'b0});
    opa = 64'h3F800000; opb = 64'h40000000;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 b2b second", {out_valid, flags_out, invalid_op, undef_op},
          {1'b1, 4'b1000, 1'b0, 1'b0});
    // inputs change while idle: no effect
    opa = 64'h40000000; opb = 64'h3F800000;
    @(negedge clk);
    check("R9 pulse ends", {out_valid, flags_out, invalid_op, undef_op},
          {1'b0, 4'b1000, 1'b0, 1'b0});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule